// File: doc/BRIEF.md
# Sticky Fault Flag Interrupt Controller

This block collects fault indications from a motor-driver supervisor and holds each one in a sticky flag until software clears it. The sources are over-temperature, undervoltage, overvoltage, two overcurrent sources (supply rail and bridge) and a line-bus event. The flags can be read back on a byte-wide address/data bus with read and write strobes. A mask register selects which flags may raise the single active-high CPU interrupt request.

Software clears a flag by writing 1 to its bit. That write is refused while the fault input is still high, so a fault that is still present always stays visible. The status register shows the two overcurrent sources only as one summary bit, and that bit cannot be written. Each source has its own write-one-to-clear bit in a separate system status register.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset, reads of the status (0x03), mask (0x04) and system status (0x05) registers return 0x00, and `irq` is 0.
- R2: A fault input that is high at a clock edge sets its flag. In the status register the flags sit at bit 4 (line event), bit 3 (over-temperature), bit 2 (undervoltage), bit 1 (overvoltage) and bit 0 (overcurrent summary). Bits 7 to 5 read 0.
- R3: Writing 1 to a status bit 4..1, or to a system status bit 1..0, clears that flag when its fault input is low.
- R4: A write of 1 has no effect while the matching fault input is high. A fault input that rises in the same cycle as a clearing write leaves the flag at 1.
- R5: Writing 0 to any flag bit leaves that flag unchanged.
- R6: Status bit 0 reads as the OR of system status bit 1 (supply rail overcurrent) and bit 0 (bridge overcurrent). A write to status bit 0 is ignored. System status bits 7 to 2 read 0.
- R7: The mask register holds bits 4..0, which enable the same sources as the status bits in the same positions. Bits 7 to 5 read 0 and ignore writes.
- R8: `irq` equals the OR over bits 4..0 of (status bit AND mask bit). It is registered, so it changes one clock after a flag or mask change.
- R9: `bus_rdata` is loaded at the clock edge where `bus_rd` is high and holds until the next read. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| cond_lin | input | 1 | Line event input |
| cond_htemp | input | 1 | Over-temperature input |
| cond_lvolt | input | 1 | Undervoltage input |
| cond_hvolt | input | 1 | Overvoltage input |
| cond_oc_rail | input | 1 | Supply rail overcurrent input |
| cond_oc_bridge | input | 1 | Bridge overcurrent input |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: an 8-bit address, addresses 0x03/0x04/0x05, and a registered request. It sweeps all 64 combinations of the six fault inputs. For each combination it then sweeps all 32 mask values, so every pairing of flags and enables is compared with a request computed arithmetically in the bench. Directed sequences cover the refused clear, a fault rising during a clearing write, writes of 0, the read-only summary bit, the unused mask bits and an unmapped read.

// File: rtl/fic_pkg.sv
package fic_pkg;
   localparam int unsigned NUM_SRC  = 6;
   localparam int unsigned NUM_IRQ  = 5;
   localparam int unsigned BYTE_W   = 8;

   // flag vector indices
   localparam int unsigned IX_OC_BRIDGE = 0;
   localparam int unsigned IX_OC_RAIL   = 1;
   localparam int unsigned IX_HVOLT     = 2;
   localparam int unsigned IX_LVOLT     = 3;
   localparam int unsigned IX_HTEMP     = 4;
   localparam int unsigned IX_LIN       = 5;

   // status register view: bits 4..1 map to flags 5..2, bit 0 is overcurrent summary
   function automatic logic [NUM_IRQ-1:0] fold_flags(input logic [NUM_SRC-1:0] f);
      return {f[IX_LIN], f[IX_HTEMP], f[IX_LVOLT], f[IX_HVOLT],
              f[IX_OC_RAIL] | f[IX_OC_BRIDGE]};
   endfunction
endpackage

// File: rtl/fic_sticky_bank.sv
module fic_sticky_bank #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_o[i] <= 1'b0;
            else if (set_i[i])  flag_o[i] <= 1'b1;   // set wins over clear
            else if (clr_i[i])  flag_o[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/fic_irq_gen.sv
module fic_irq_gen #(
   parameter int unsigned W          = 5,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flags_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   logic req_c;
   assign req_c = |(flags_i & en_i);

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= req_c;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq_o = req_c;
      end
   endgenerate
endmodule

// File: rtl/fic_read_port.sv
module fic_read_port #(
   parameter int unsigned         ADDR_W    = 8,
   parameter int unsigned         DATA_W    = 8,
   parameter logic [ADDR_W-1:0]   STAT_ADDR = 'h03,
   parameter logic [ADDR_W-1:0]   MASK_ADDR = 'h04,
   parameter logic [ADDR_W-1:0]   SYS_ADDR  = 'h05
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] stat_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic [DATA_W-1:0] sys_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] sel_c;

   always_comb begin
      if      (addr_i == STAT_ADDR) sel_c = stat_i;
      else if (addr_i == MASK_ADDR) sel_c = mask_i;
      else if (addr_i == SYS_ADDR)  sel_c = sys_i;
      else                          sel_c = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= sel_c;
   end
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl #(
   parameter int unsigned       ADDR_W         = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR      = 'h03,
   parameter logic [ADDR_W-1:0] MASK_ADDR      = 'h04,
   parameter logic [ADDR_W-1:0] SYS_ADDR       = 'h05,
   parameter bit                IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   input  logic              cond_lin,
   input  logic              cond_htemp,
   input  logic              cond_lvolt,
   input  logic              cond_hvolt,
   input  logic              cond_oc_rail,
   input  logic              cond_oc_bridge,
   output logic              irq
);
   import fic_pkg::*;

   localparam int unsigned PAD_STAT = BYTE_W - NUM_IRQ;
   localparam int unsigned PAD_SYS  = BYTE_W - 2;

   // elaboration-time configuration checks
   generate
      if (ADDR_W < 3) begin : g_bad_addr_w
         $error("fault_irq_ctrl: ADDR_W must be at least 3");
      end
      if (STAT_ADDR == MASK_ADDR || STAT_ADDR == SYS_ADDR || MASK_ADDR == SYS_ADDR) begin : g_bad_map
         $error("fault_irq_ctrl: register addresses must differ");
      end
   endgenerate

   logic [NUM_SRC-1:0] cond_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] flags;
   logic [NUM_IRQ-1:0] sum_flags;
   logic [NUM_IRQ-1:0] mask_q;
   logic               wr_stat, wr_mask, wr_sys;
   logic [BYTE_W-1:0]  stat_byte, mask_byte, sys_byte;

   assign cond_vec = {cond_lin, cond_htemp, cond_lvolt, cond_hvolt, cond_oc_rail, cond_oc_bridge};

   assign wr_stat = bus_wr && (bus_addr == STAT_ADDR);
   assign wr_mask = bus_wr && (bus_addr == MASK_ADDR);
   assign wr_sys  = bus_wr && (bus_addr == SYS_ADDR);

   // status bit 0 (summary) is not writable; sources clear through the system register
   always_comb begin
      clr_vec               = '0;
      clr_vec[IX_LIN]       = wr_stat & bus_wdata[4];
      clr_vec[IX_HTEMP]     = wr_stat & bus_wdata[3];
      clr_vec[IX_LVOLT]     = wr_stat & bus_wdata[2];
      clr_vec[IX_HVOLT]     = wr_stat & bus_wdata[1];
      clr_vec[IX_OC_RAIL]   = wr_sys  & bus_wdata[1];
      clr_vec[IX_OC_BRIDGE] = wr_sys  & bus_wdata[0];
   end

   fic_sticky_bank #(.N(NUM_SRC)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (cond_vec),
      .clr_i  (clr_vec),
      .flag_o (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= bus_wdata[NUM_IRQ-1:0];
   end

   assign sum_flags = fold_flags(flags);
   assign stat_byte = {{PAD_STAT{1'b0}}, sum_flags};
   assign mask_byte = {{PAD_STAT{1'b0}}, mask_q};
   assign sys_byte  = {{PAD_SYS{1'b0}}, flags[IX_OC_RAIL], flags[IX_OC_BRIDGE]};

   fic_irq_gen #(.W(NUM_IRQ), .REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (sum_flags),
      .en_i    (mask_q),
      .irq_o   (irq)
   );

   fic_read_port #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (BYTE_W),
      .STAT_ADDR (STAT_ADDR),
      .MASK_ADDR (MASK_ADDR),
      .SYS_ADDR  (SYS_ADDR)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_i    (bus_rd),
      .addr_i  (bus_addr),
      .stat_i  (stat_byte),
      .mask_i  (mask_byte),
      .sys_i   (sys_byte),
      .rdata_o (bus_rdata)
   );
endmodule

// File: rtl/fic_checker.sv
module fic_checker #(
   parameter int unsigned       ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h03,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 'h04,
   parameter logic [ADDR_W-1:0] SYS_ADDR  = 'h05
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [7:0]        bus_rdata,
   input logic [5:0]        cond_vec,
   input logic [5:0]        flags,
   input logic [4:0]        sum_flags,
   input logic [4:0]        mask_q,
   input logic              irq
);
   // R2 / R4: any asserted input leaves its flag set on the next cycle
   a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|cond_vec) |=> ((flags & $past(cond_vec)) == $past(cond_vec)));

   // R5 / R3: a flag can only fall after a write cycle
   a_r5_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr) |=> ((flags & $past(flags)) == $past(flags)));

   // R8: request follows the masked status one cycle later
   a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == |($past(sum_flags & mask_q))));

   // R7: upper mask bits read back as zero
   a_r7_mask_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == MASK_ADDR) |=> (bus_rdata[7:5] == 3'b000));

   // R9: unmapped reads return zero
   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr != STAT_ADDR && bus_addr != MASK_ADDR && bus_addr != SYS_ADDR)
      |=> (bus_rdata == 8'h00));
endmodule

bind fault_irq_ctrl fic_checker #(
   .ADDR_W    (ADDR_W),
   .STAT_ADDR (STAT_ADDR),
   .MASK_ADDR (MASK_ADDR),
   .SYS_ADDR  (SYS_ADDR)
) u_fic_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .cond_vec  (cond_vec),
   .flags     (flags),
   .sum_flags (sum_flags),
   .mask_q    (mask_q),
   .irq       (irq)
);

// File: tb/fault_irq_ctrl_tb_top.sv
module fault_irq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic [5:0] cond_r = '0;   // {lin, htemp, lvolt, hvolt, oc_rail, oc_bridge}
   logic       irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench model
   logic [5:0] m_flags = '0;
   logic [4:0] m_mask  = '0;

   always #4 clk = ~clk;   // 125 MHz

   fault_irq_ctrl dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_addr       (bus_addr),
      .bus_wdata      (bus_wdata),
      .bus_wr         (bus_wr),
      .bus_rd         (bus_rd),
      .bus_rdata      (bus_rdata),
      .cond_lin       (cond_r[5]),
      .cond_htemp     (cond_r[4]),
      .cond_lvolt     (cond_r[3]),
      .cond_hvolt     (cond_r[2]),
      .cond_oc_rail   (cond_r[1]),
      .cond_oc_bridge (cond_r[0]),
      .irq            (irq)
   );

   function automatic logic [7:0] exp_stat(input logic [5:0] f);
      return {3'b000, f[5], f[4], f[3], f[2], f[1] | f[0]};
   endfunction
   function automatic logic [7:0] exp_sys(input logic [5:0] f);
      return {6'b0, f[1], f[0]};
   endfunction

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // one clock with the given strobes; model updated per the set/clear rules
   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      logic [5:0] clr;
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      clr = '0;
      if (a == 8'h03) clr[5:2] = d[4:1];
      if (a == 8'h05) clr[1:0] = d[1:0];
      @(posedge clk);
      m_flags = cond_r | (m_flags & ~clr);
      if (a == 8'h04) m_mask = d[4:0];
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk);
      m_flags = m_flags | cond_r;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse_cond(input logic [5:0] c);
      @(negedge clk);
      cond_r = c;
      @(posedge clk);
      m_flags = m_flags | cond_r;
      @(negedge clk);
      cond_r = '0;
   endtask

   task automatic check_irq(input string req);
      @(posedge clk);
      m_flags = m_flags | cond_r;
      @(negedge clk);
      check({7'b0, irq}, {7'b0, |(exp_stat(m_flags)[4:0] & m_mask)}, req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      bus_read(8'h03, rd); check(rd, 8'h00, "R1 status");
      bus_read(8'h04, rd); check(rd, 8'h00, "R1 mask");
      bus_read(8'h05, rd); check(rd, 8'h00, "R1 sys");
      check({7'b0, irq}, 8'h00, "R1 irq");

      // R2 / R6 / R8: every input pattern against every mask
      for (int p = 0; p < 64; p++) begin
         bus_write(8'h03, 8'h1E);
         bus_write(8'h05, 8'h03);
         pulse_cond(p[5:0]);
         bus_read(8'h03, rd); check(rd, exp_stat(m_flags), "R2 status pattern");
         bus_read(8'h05, rd); check(rd, exp_sys(m_flags), "R6 sys pattern");
         for (int m = 0; m < 32; m++) begin
            bus_write(8'h04, m[7:0]);
            check_irq("R8 irq mask sweep");
         end
      end

      // R3: clears with inputs low
      bus_write(8'h04, 8'h00);
      pulse_cond(6'h3F);
      bus_write(8'h03, 8'h1E);
      bus_read(8'h03, rd); check(rd, 8'h01, "R3 status clear");
      bus_write(8'h05, 8'h03);
      bus_read(8'h03, rd); check(rd, 8'h00, "R3 oc sources cleared");

      // R5: writing zeros keeps flags
      pulse_cond(6'h3F);
      bus_write(8'h03, 8'h00);
      bus_write(8'h05, 8'h00);
      bus_read(8'h03, rd); check(rd, 8'h1F, "R5 status zeros");
      bus_read(8'h05, rd); check(rd, 8'h03, "R5 sys zeros");

      // R6: summary bit not writable; one source cleared leaves summary set
      bus_write(8'h03, 8'h01);
      bus_read(8'h03, rd); check(rd, exp_stat(m_flags), "R6 summary write ignored");
      check(rd & 8'h01, 8'h01, "R6 summary still set");
      bus_write(8'h05, 8'h02);
      bus_read(8'h05, rd); check(rd, 8'h01, "R6 rail cleared only");
      bus_read(8'h03, rd); check(rd & 8'h01, 8'h01, "R6 summary from bridge");
      bus_write(8'h05, 8'h01);
      bus_read(8'h03, rd); check(rd & 8'h01, 8'h00, "R6 summary cleared");

      // R4: clear refused while input high
      bus_write(8'h03, 8'h1E);
      @(negedge clk); cond_r = 6'b010000;
      bus_write(8'h03, 8'h08);
      bus_read(8'h03, rd); check(rd, 8'h08, "R4 htemp clear refused");
      @(negedge clk); cond_r = 6'b000010;
      bus_write(8'h05, 8'h02);
      bus_read(8'h05, rd); check(rd, 8'h02, "R4 rail clear refused");
      @(negedge clk); cond_r = '0;
      bus_write(8'h03, 8'h08);
      bus_write(8'h05, 8'h02);
      bus_read(8'h03, rd); check(rd, 8'h00, "R4 clear after input drops");
      // R4: input rises in same cycle as clearing write
      @(negedge clk); cond_r = 6'b100000;
      bus_write(8'h03, 8'h10);
      @(negedge clk); cond_r = '0;
      bus_read(8'h03, rd); check(rd, 8'h10, "R4 set wins same cycle");
      bus_write(8'h03, 8'h10);

      // R7: upper mask bits
      bus_write(8'h04, 8'hFF);
      bus_read(8'h04, rd); check(rd, 8'h1F, "R7 mask upper ignored");
      bus_write(8'h04, 8'hE5);
      bus_read(8'h04, rd); check(rd, 8'h05, "R7 mask value");

      // R8: one-cycle latency on flag rise
      bus_write(8'h04, 8'h08);
      @(negedge clk); cond_r = 6'b010000;
      @(posedge clk); @(negedge clk); cond_r = '0;
      check({7'b0, irq}, 8'h00, "R8 irq not yet");
      @(posedge clk); @(negedge clk);
      check({7'b0, irq}, 8'h01, "R8 irq after one clock");
      m_flags = m_flags | 6'b010000;

      // R9: registered read and unmapped address
      bus_read(8'h07, rd); check(rd, 8'h00, "R9 unmapped");
      bus_read(8'h03, rd);
      @(negedge clk); bus_addr = 8'h04;
      @(negedge clk); check(bus_rdata, 8'h08, "R9 rdata holds without strobe");

      finish_run();
   end
endmodule